// File: doc/BRIEF.md
# SDRAM Four-Bank Open-Row Manager

This block sits between a request stage that has already split a memory access into bank, row, column, length and direction, and a transfer stage that drives the column commands and moves the data. For each of four SDRAM banks it records whether a row is open and which row that is. It then decides what each request needs before the transfer stage can run it. A request to a closed bank needs an activate. A request to the row already open needs nothing. A request to a different row in an open bank needs a precharge followed by an activate. Rows stay open after an access, so a run of accesses to the same page costs no row commands.

The block drives its own SDR command slot (chip select, row strobe, column strobe, write enable, address and bank) and holds NOP on it whenever it has nothing to issue. Separate cycle counters for precharge-to-activate and activate-to-column spacing hold back the next step for a bank until that bank's spacing has elapsed. A refresh engine asks for the memory with a request line. Once no column transfer is running, the block issues a precharge of all banks, marks every bank closed and raises its grant in that same cycle. The grant stays high until the refresh engine drops its request.

Top module: `sdram_bank_mgr`

## Requirements
- R1: After reset the command slot carries NOP, `req_ready` is 1, and `xfer_valid` and `ref_gnt` are 0.
- R2: A request accepted for a closed bank puts ACTIVE ({cs_n,ras_n,cas_n,we_n}=0011) on the bus two cycles after acceptance, with that bank on `sd_ba` and the row on `sd_addr`. `xfer_valid` rises T_RCD cycles after the ACTIVE cycle.
- R3: A request to the row open in its bank (page hit) issues no PRECHARGE or ACTIVE, and `xfer_valid` rises two cycles after acceptance.
- R4: A request to an open bank with a different row issues PRECHARGE (0010) for that bank with `sd_addr[10]`=0 two cycles after acceptance. ACTIVE for the new row follows T_RP cycles after the PRECHARGE, and `xfer_valid` follows T_RCD cycles after the ACTIVE.
- R5: Each bank keeps its open row independently, so opening a row in one bank leaves the other banks' rows open.
- R6: While `xfer_valid` is 1 and `xfer_ready` is 0, `xfer_valid` stays 1 and `xfer_bank`, `xfer_col`, `xfer_len` and `xfer_write` stay unchanged.
- R7: `ref_gnt` rises only while no column transfer is running (`xfer_busy` low in the cycle before) and no request is in flight. It rises in the same cycle as a PRECHARGE with `sd_addr[10]`=1, one cycle after `xfer_busy` falls.
- R8: After a refresh grant every bank counts as closed, so the next request to any previously open row gets an ACTIVE.
- R9: In every cycle with nothing to issue, including the cycles of a held grant, the slot carries NOP (0111). The encodings also reserve READ 0101, WRITE 0100, AUTO REFRESH 0001, LOAD MODE 0000 and BURST TERMINATE 0110.
- R10: `req_ready` is 0 while `ref_req` is 1 and while a request is in flight.
- R11: `xfer_col`, `xfer_len` and `xfer_write` carry the column, length and direction of the accepted request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_bank | input | BA_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Starting column |
| req_len | input | LEN_W | Transfer length |
| req_write | input | 1 | 1 for write, 0 for read |
| xfer_valid | output | 1 | Request ready for the transfer stage |
| xfer_ready | input | 1 | Transfer stage takes the request |
| xfer_bank | output | BA_W | Bank handed on |
| xfer_col | output | COL_W | Column handed on |
| xfer_len | output | LEN_W | Length handed on |
| xfer_write | output | 1 | Direction handed on |
| xfer_busy | input | 1 | A column transfer is running |
| ref_req | input | 1 | Refresh engine asks for the memory |
| ref_gnt | output | 1 | All banks closed; memory handed to refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Row or precharge address |
| sd_ba | output | BA_W | Bank select |

## Verification
The row commands and handoffs fall at fixed offsets from the cycle a request is accepted. Both ACTIVE on a closed bank and the handoff on a page hit come two cycles later. On a row miss, PRECHARGE comes two cycles later, ACTIVE T_RP cycles after that, and the handoff T_RCD cycles after the ACTIVE. The all-bank precharge and the grant appear together one cycle after `xfer_busy` falls. The bench counts clock cycles and records every non-NOP command with its cycle index at the falling edge. Each scenario then compares the logged cycles and the first cycle of `xfer_valid` against the acceptance cycle plus these offsets, and compares the command count, so any stray command is caught as well.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMODE = 4'b0000,
        CMD_AREF  = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_BTERM = 4'b0110,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_HAND,
        ST_REF
    } mgr_state_e;

    localparam int PRE_ALL_BIT = 10;

endpackage

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
    parameter int ROW_W = 13,
    parameter int T_RP  = 3,
    parameter int T_RCD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             clr_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             is_open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             ready_o
);
    localparam int T_MAX = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int TW    = (T_MAX < 2) ? 1 : $clog2(T_MAX + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [TW-1:0]    timer;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.timer != '0) s_d.timer = s_q.timer - 1'b1;
        if (pre_i || clr_i) begin
            s_d.open  = 1'b0;
            s_d.timer = TW'(T_RP - 1);
        end else if (act_i) begin
            s_d.open  = 1'b1;
            s_d.row   = row_i;
            s_d.timer = TW'(T_RCD - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign is_open_o = s_q.open;
    assign row_o     = s_q.row;
    assign ready_o   = (s_q.timer == '0);

    // R2: activate only reaches a closed bank whose spacing has elapsed
    assert_act_on_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (!s_q.open && s_q.timer == '0));

    // R4: single-bank precharge only reaches an open, settled bank
    assert_pre_on_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> (s_q.open && s_q.timer == '0));

endmodule

// File: rtl/sdram_page_lookup.sv
module sdram_page_lookup #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0]            bank_open,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
    input  logic [NUM_BANKS-1:0]            bank_rdy,
    input  logic [BA_W-1:0]                 sel_bank,
    input  logic [ROW_W-1:0]                sel_row,
    output logic                            sel_open,
    output logic                            sel_hit,
    output logic                            sel_rdy
);
    always_comb begin
        sel_open = 1'b0;
        sel_hit  = 1'b0;
        sel_rdy  = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_bank == BA_W'(b)) begin
                sel_open = bank_open[b];
                sel_hit  = bank_open[b] && (bank_row[b] == sel_row);
                sel_rdy  = bank_rdy[b];
            end
        end
    end
endmodule

// File: rtl/sdram_bank_mgr.sv
module sdram_bank_mgr
    import sdram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int LEN_W     = 4,
    parameter int ADDR_W    = 13,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 2,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [BA_W-1:0]   xfer_bank,
    output logic [COL_W-1:0]  xfer_col,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_write,
    input  logic              xfer_busy,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);
    typedef struct packed {
        mgr_state_e        st;
        logic [BA_W-1:0]   bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [LEN_W-1:0]  len;
        logic              wr;
        sd_cmd_e           cmd;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              gnt;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        st: ST_IDLE, bank: '0, row: '0, col: '0, len: '0, wr: 1'b0,
        cmd: CMD_NOP, addr: '0, ba: '0, gnt: 1'b0
    };

    ctl_t c_d, c_q;

    logic [NUM_BANKS-1:0]            act_v, pre_v;
    logic                            clr_all;
    logic [NUM_BANKS-1:0]            bank_open, bank_rdy;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic                            sel_open, sel_hit, sel_rdy;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_slot #(
            .ROW_W (ROW_W),
            .T_RP  (T_RP),
            .T_RCD (T_RCD)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act_v[b]),
            .pre_i     (pre_v[b]),
            .clr_i     (clr_all),
            .row_i     (c_q.row),
            .is_open_o (bank_open[b]),
            .row_o     (bank_row[b]),
            .ready_o   (bank_rdy[b])
        );
    end

    sdram_page_lookup #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_lookup (
        .bank_open (bank_open),
        .bank_row  (bank_row),
        .bank_rdy  (bank_rdy),
        .sel_bank  (c_q.bank),
        .sel_row   (c_q.row),
        .sel_open  (sel_open),
        .sel_hit   (sel_hit),
        .sel_rdy   (sel_rdy)
    );

    assign req_ready = (c_q.st == ST_IDLE) && !ref_req;

    always_comb begin
        c_d     = c_q;
        c_d.cmd  = CMD_NOP;
        c_d.addr = '0;
        c_d.ba   = '0;
        act_v   = '0;
        pre_v   = '0;
        clr_all = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (ref_req && !xfer_busy) begin
                    c_d.st                = ST_REF;
                    c_d.cmd               = CMD_PRE;
                    c_d.addr[PRE_ALL_BIT] = 1'b1;
                    c_d.gnt               = 1'b1;
                    clr_all               = 1'b1;
                end else if (req_valid && req_ready) begin
                    c_d.st   = ST_DECIDE;
                    c_d.bank = req_bank;
                    c_d.row  = req_row;
                    c_d.col  = req_col;
                    c_d.len  = req_len;
                    c_d.wr   = req_write;
                end
            end
            ST_DECIDE: begin
                if (sel_rdy) begin
                    if (sel_hit) begin
                        c_d.st = ST_HAND;
                    end else if (sel_open) begin
                        c_d.cmd           = CMD_PRE;
                        c_d.ba            = c_q.bank;
                        pre_v[c_q.bank]   = 1'b1;
                    end else begin
                        c_d.cmd           = CMD_ACT;
                        c_d.ba            = c_q.bank;
                        c_d.addr          = ADDR_W'(c_q.row);
                        act_v[c_q.bank]   = 1'b1;
                    end
                end
            end
            ST_HAND: begin
                if (xfer_ready) c_d.st = ST_IDLE;
            end
            ST_REF: begin
                if (!ref_req) begin
                    c_d.st  = ST_IDLE;
                    c_d.gnt = 1'b0;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= CTL_RESET;
        else        c_q <= c_d;
    end

    assign xfer_valid = (c_q.st == ST_HAND);
    assign xfer_bank  = c_q.bank;
    assign xfer_col   = c_q.col;
    assign xfer_len   = c_q.len;
    assign xfer_write = c_q.wr;
    assign ref_gnt    = c_q.gnt;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = c_q.cmd;
    assign sd_addr    = c_q.addr;
    assign sd_ba      = c_q.ba;

    // R6: a handed-on request holds until the transfer stage takes it
    assert_xfer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=>
            (xfer_valid && $stable({xfer_bank, xfer_col, xfer_len, xfer_write})));

    // R7: grant only after a cycle with no column transfer running
    assert_gnt_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_gnt) |-> !$past(xfer_busy));

    // R7: grant appears together with the all-bank precharge
    assert_gnt_preall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_gnt) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_PRE
                            && sd_addr[PRE_ALL_BIT]));

    // R9: a held grant leaves the bus on NOP
    assert_nop_in_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_gnt && $past(ref_gnt)) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));

    // R10: no new request while refresh is pending
    assert_block_on_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !req_ready);

endmodule

// File: tb/sdram_bank_mgr_bench.sv
module sdram_bank_mgr_bench;
    localparam int NB = 4, RW = 13, CW = 9, LW = 4, AW = 13, TRP = 3, TRCD = 2;
    localparam int BW = $clog2(NB);
    localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, PRE = 4'b0010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, xfer_ready = 1'b0;
    logic xfer_busy = 1'b0, ref_req = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [LW-1:0] req_len = '0;
    logic req_ready, xfer_valid, xfer_write, ref_gnt;
    logic [BW-1:0] xfer_bank, sd_ba;
    logic [CW-1:0] xfer_col;
    logic [LW-1:0] xfer_len;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [AW-1:0] sd_addr;

    int checks = 0, errors = 0, cyc = 0;
    int lg_n = 0;
    logic [3:0]    lg_cmd [64];
    logic [BW-1:0] lg_ba  [64];
    logic [AW-1:0] lg_addr[64];
    int            lg_cyc [64];

    always #5 clk = ~clk;

    sdram_bank_mgr #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .LEN_W(LW),
                     .ADDR_W(AW), .T_RP(TRP), .T_RCD(TRCD)) u_sdram_bank_mgr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .req_write(req_write), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_bank(xfer_bank), .xfer_col(xfer_col), .xfer_len(xfer_len),
        .xfer_write(xfer_write), .xfer_busy(xfer_busy), .ref_req(ref_req),
        .ref_gnt(ref_gnt), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba));

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != NOP && lg_n < 64) begin
            lg_cmd[lg_n]  <= {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            lg_ba[lg_n]   <= sd_ba;
            lg_addr[lg_n] <= sd_addr;
            lg_cyc[lg_n]  <= cyc;
            lg_n          <= lg_n + 1;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        if (cyc == 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input int bank, input int row, input int col, input int len,
                         input logic wr, output int acc);
        @(negedge clk);
        req_bank = BW'(bank); req_row = RW'(row); req_col = CW'(col);
        req_len = LW'(len); req_write = wr; req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic take(input int bank, input int col, input int len, input logic wr,
                        input int hold, output int xc);
        @(negedge clk); #1;
        while (!xfer_valid) begin @(negedge clk); #1; end
        xc = cyc;
        chk("R11 xfer_bank", int'(xfer_bank), bank);
        chk("R11 xfer_col", int'(xfer_col), col);
        chk("R11 xfer_len", int'(xfer_len), len);
        chk("R11 xfer_write", int'(xfer_write), int'(wr));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk); #1;
            chk("R6 held valid", int'(xfer_valid), 1);
            chk("R6 held col", int'(xfer_col), col);
        end
        xfer_ready = 1'b1;
        @(negedge clk);
        xfer_ready = 1'b0;
        #1;
        chk("R6 released after ready", int'(xfer_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 cmd NOP", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(NOP));
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 xfer_valid", int'(xfer_valid), 0);
        chk("R1 ref_gnt", int'(ref_gnt), 0);
    endtask

    task automatic t_closed(input int bank, input int row, input int col, input string tag);
        int base, acc, xc;
        base = lg_n;
        issue(bank, row, col, 5, 1'b1, acc);
        take(bank, col, 5, 1'b1, 3, xc);
        chk({tag, " R2 one command"}, lg_n - base, 1);
        chk({tag, " R2 ACT code"}, int'(lg_cmd[base]), int'(ACT));
        chk({tag, " R2 ACT bank"}, int'(lg_ba[base]), bank);
        chk({tag, " R2 ACT row"}, int'(lg_addr[base]), row);
        chk({tag, " R2 ACT cycle"}, lg_cyc[base], acc + 2);
        chk({tag, " R2 handoff cycle"}, xc, acc + 2 + TRCD);
    endtask

    task automatic t_hit(input int bank, input int row, input string tag);
        int base, acc, xc;
        base = lg_n;
        issue(bank, row, 17, 2, 1'b0, acc);
        take(bank, 17, 2, 1'b0, 0, xc);
        chk({tag, " no row command"}, lg_n - base, 0);
        chk({tag, " handoff cycle"}, xc, acc + 2);
    endtask

    task automatic t_miss(input int bank, input int row);
        int base, acc, xc;
        base = lg_n;
        issue(bank, row, 3, 8, 1'b1, acc);
        take(bank, 3, 8, 1'b1, 0, xc);
        chk("R4 two commands", lg_n - base, 2);
        chk("R4 PRE code", int'(lg_cmd[base]), int'(PRE));
        chk("R4 PRE bank", int'(lg_ba[base]), bank);
        chk("R4 PRE A10 low", int'(lg_addr[base][10]), 0);
        chk("R4 PRE cycle", lg_cyc[base], acc + 2);
        chk("R4 ACT code", int'(lg_cmd[base+1]), int'(ACT));
        chk("R4 ACT row", int'(lg_addr[base+1]), row);
        chk("R4 ACT cycle", lg_cyc[base+1], acc + 2 + TRP);
        chk("R4 handoff cycle", xc, acc + 2 + TRP + TRCD);
    endtask

    task automatic t_refresh();
        int base, n, gc;
        base = lg_n;
        @(negedge clk);
        ref_req = 1'b1; xfer_busy = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R7 no grant while busy", int'(ref_gnt), 0);
            chk("R10 ready low under refresh", int'(req_ready), 0);
        end
        chk("R7 no command while busy", lg_n - base, 0);
        n = cyc;
        xfer_busy = 1'b0;
        @(negedge clk); #1;
        while (!ref_gnt) begin @(negedge clk); #1; end
        gc = cyc;
        chk("R7 grant cycle", gc, n + 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R9 grant held", int'(ref_gnt), 1);
        end
        chk("R9 only one command in grant", lg_n - base, 1);
        chk("R7 PRE-all code", int'(lg_cmd[base]), int'(PRE));
        chk("R7 PRE-all A10 high", int'(lg_addr[base][10]), 1);
        chk("R7 PRE-all same cycle as grant", lg_cyc[base], gc);
        ref_req = 1'b0;
        @(negedge clk); #1;
        chk("R7 grant dropped", int'(ref_gnt), 0);
        chk("R10 ready back", int'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_closed(0, 5, 40, "bank0");
        t_hit(0, 5, "R3 hit bank0");
        t_closed(1, 9, 12, "bank1");
        t_hit(0, 5, "R5 bank0 kept");
        t_hit(1, 9, "R5 bank1 kept");
        t_miss(0, 7);
        t_hit(0, 7, "R3 hit new row");
        t_refresh();
        t_closed(1, 9, 6, "R8 bank1 after refresh");
        t_closed(0, 7, 2, "R8 bank0 after refresh");
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule